// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides a fast input clock by one of two adjacent ratios, P or P+1, and marks the end of each divided period with a single-cycle pulse. That pulse serves as the count enable for the swallow and main counters further down a frequency synthesizer's feedback path. A two-bit field selects P from four powers of two between 8 and 64. A one-bit modulus-control input requests the longer ratio.

The block runs in one synchronous clock domain, so each rising edge of `clk` is one input cycle. Its core is a counter that divides by 4, or by 5 on request. Behind the core sit up to four binary toggle stages, and the ratio field decides how many of them are active. The core adds its fifth state only when modulus control was requested and every active stage is at its terminal value. This puts exactly one extra input cycle into the period.

Both the ratio field and the modulus-control input are sampled once per period, at the boundary, and held until the next boundary. A change made in the middle of a period therefore only affects the period that follows the next pulse.

Top module: `dualmod_prescaler`

## Requirements
- R1: `ratio_sel` encodes P as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. With modulus control low, two consecutive `div_pulse` assertions are exactly P rising edges apart.
- R2: When modulus control was captured high, the period lasts P+1 rising edges. Exactly one cycle is added, whatever the ratio.
- R3: `div_pulse` is high for one clock cycle per period and is low in the cycle that follows each pulse.
- R4: `mod_ctl` is captured only at a rising edge where `div_pulse` is high, or at an edge where `rst` is high. Changing it at any other time leaves the current period length unchanged.
- R5: `ratio_sel` is captured under the same rule as `mod_ctl`. A change in mid-period leaves the current period length unchanged, and the new ratio takes effect from the period after the next pulse.
- R6: `rst` is synchronous and active high. While it is high, `div_pulse` stays low and all stages are cleared, and the values on `ratio_sel` and `mod_ctl` are captured. Let L be the period length those captured values select. The first `div_pulse` then appears after exactly L-1 rising edges with `rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; one rising edge per input cycle |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Selects P (00=8, 01=16, 10=32, 11=64) |
| mod_ctl | input | 1 | High requests a P+1 period |
| div_pulse | output | 1 | One-cycle pulse at the end of each divided period |

## Verification
The hardest case to reach from the ports is an input change that arrives in the middle of a period. The bench has to show that such a change leaves the running period's length alone and only appears one boundary later. To do this, it drives new values a few cycles after a pulse, measures the interval to the next pulse, and then measures the interval after that. It also moves from the longest ratio with the extra cycle straight to the shortest ratio, and back again. Finally, it asserts reset in the middle of a period to check the reload and the length of the first period after reset.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    localparam int STAGES_MAX = 4;
    localparam int CORE_W     = 3;
    localparam int LEN_W      = 7;

    typedef enum logic [1:0] {
        RATIO_8  = 2'b00,
        RATIO_16 = 2'b01,
        RATIO_32 = 2'b10,
        RATIO_64 = 2'b11
    } ratio_e;

    typedef struct packed {
        ratio_e ratio;
        logic   stretch_req;
    } period_cfg_t;

    // Bit i set when binary stage i takes part for ratio r.
    function automatic logic [STAGES_MAX-1:0] stage_mask(ratio_e r);
        logic [STAGES_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < STAGES_MAX; i++) begin
            if (i <= int'(r)) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Input cycles in one period for a ratio and an extend request.
    function automatic logic [LEN_W-1:0] period_len(ratio_e r, logic ext);
        return LEN_W'(8 << int'(r)) + LEN_W'(ext);
    endfunction

endpackage

// File: rtl/dmp_core45.sv
module dmp_core45
    import dmp_pkg::*;
#(
    parameter int W = CORE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stretch,
    output logic [W-1:0] cnt,
    output logic         at_last
);

    localparam logic [W-1:0] LAST4 = W'(3);
    localparam logic [W-1:0] LAST5 = W'(4);

    logic [W-1:0] last_val;

    always_comb begin
        last_val = stretch ? LAST5 : LAST4;
        at_last  = (cnt == last_val);
    end

    always_ff @(posedge clk) begin
        if (rst || at_last) cnt <= '0;
        else                cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/dmp_binstages.sv
module dmp_binstages #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [N-1:0] mask,
    output logic [N-1:0] q,
    output logic         term
);

    logic [N-1:0] carry;

    always_comb begin
        carry[0] = adv;
        for (int i = 1; i < N; i++) begin
            carry[i] = carry[i-1] & q[i-1];
        end
        term = &(q | ~mask);
    end

    for (genvar g = 0; g < N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || (adv && term))        q[g] <= 1'b0;
            else if (carry[g] && mask[g])    q[g] <= ~q[g];
        end
    end

endmodule

// File: rtl/dmp_modctl.sv
module dmp_modctl
    import dmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic [1:0]  ratio_sel,
    input  logic        mod_ctl,
    output period_cfg_t cur
);

    always_ff @(posedge clk) begin
        if (rst || boundary) begin
            cur <= '{ratio: ratio_e'(ratio_sel), stretch_req: mod_ctl};
        end
    end

endmodule

// File: rtl/dualmod_prescaler.sv
module dualmod_prescaler
    import dmp_pkg::*;
#(
    parameter int STAGES = STAGES_MAX,
    parameter int CW     = CORE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    input  logic       mod_ctl,
    output logic       div_pulse
);

    period_cfg_t       cur;
    ratio_e            cfg_q;
    logic              mod_q;
    logic [CW-1:0]     core_cnt;
    logic              core_last;
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] mask;
    logic              stage_term;
    logic              stretch;
    logic              boundary;

    assign cfg_q    = cur.ratio;
    assign mod_q    = cur.stretch_req;
    assign mask     = STAGES'(stage_mask(cfg_q));
    assign stretch  = mod_q && stage_term;
    assign boundary = core_last && stage_term;
    assign div_pulse = boundary && !rst;

    dmp_modctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .ratio_sel (ratio_sel),
        .mod_ctl   (mod_ctl),
        .cur       (cur)
    );

    dmp_core45 #(.W(CW)) u_core (
        .clk     (clk),
        .rst     (rst),
        .stretch (stretch),
        .cnt     (core_cnt),
        .at_last (core_last)
    );

    dmp_binstages #(.N(STAGES)) u_stg (
        .clk  (clk),
        .rst  (rst),
        .adv  (core_last),
        .mask (mask),
        .q    (stage_q),
        .term (stage_term)
    );

endmodule

// File: rtl/dmp_chk.sv
module dmp_chk
    import dmp_pkg::*;
#(
    parameter int N  = STAGES_MAX,
    parameter int CW = CORE_W
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    ratio_sel,
    input logic          mod_ctl,
    input logic          div_pulse,
    input logic [1:0]    cfg_q,
    input logic          mod_q,
    input logic [CW-1:0] core_cnt,
    input logic [N-1:0]  stage_q
);

    logic             seen;
    logic [LEN_W:0]   gap;
    logic [LEN_W-1:0] exp_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            gap     <= '0;
            exp_len <= '0;
        end else if (div_pulse) begin
            seen    <= 1'b1;
            gap     <= (LEN_W+1)'(1);
            exp_len <= period_len(ratio_e'(ratio_sel), mod_ctl);
        end else begin
            gap <= gap + (LEN_W+1)'(1);
        end
    end

    // R1 and R2: spacing between pulses matches the captured ratio and request
    a_r1_period_len: assert property (@(posedge clk) disable iff (rst)
        (seen && div_pulse) |-> (gap == {1'b0, exp_len}));

    // R1: stages beyond the selected ratio stay idle
    a_r1_idle_stages: assert property (@(posedge clk) disable iff (rst)
        ((stage_q & ~N'(stage_mask(ratio_e'(cfg_q)))) == '0));

    // R2: core never passes its fifth state and uses it only when requested
    a_r2_core_range: assert property (@(posedge clk) disable iff (rst)
        (core_cnt <= CW'(4)) && ((core_cnt == CW'(4)) -> mod_q));

    // R3: pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R4: captured request holds between boundaries
    a_r4_mod_held: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(mod_q));

    // R5: captured ratio holds between boundaries
    a_r5_ratio_held: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(cfg_q));

endmodule

bind dualmod_prescaler dmp_chk #(.N(STAGES), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .cfg_q     (cfg_q),
    .mod_q     (mod_q),
    .core_cnt  (core_cnt),
    .stage_q   (stage_q)
);

// File: tb/sim_dualmod_prescaler.sv
`timescale 1ns/1ps
module sim_dualmod_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ratio_sel = 2'b01;
    logic       mod_ctl = 1'b1;
    logic       div_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dualmod_prescaler u0 (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (ratio_sel),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse)
    );

    // {ratio_sel, mod_ctl, expected period}: values derived from R1/R2
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        {2'b00, 1'b0, 7'd8 },  {2'b00, 1'b1, 7'd9 },
        {2'b01, 1'b0, 7'd16},  {2'b01, 1'b1, 7'd17},
        {2'b10, 1'b0, 7'd32},  {2'b10, 1'b1, 7'd33},
        {2'b11, 1'b0, 7'd64},  {2'b11, 1'b1, 7'd65},
        {2'b00, 1'b0, 7'd8 },  {2'b11, 1'b1, 7'd65},
        {2'b01, 1'b0, 7'd16},  {2'b00, 1'b1, 7'd9 }
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedges until div_pulse is seen high; first_hi is the sample after the start.
    task automatic count_to_pulse(output int n, output logic first_hi);
        n = 0;
        first_hi = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) first_hi = div_pulse;
        end while (!div_pulse && n < 300);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int   n;
        logic fh;

        // R6: quiet during reset, capture 16/17 with request high
        repeat (4) begin
            @(negedge clk);
            check("R6 pulse low in reset", int'(div_pulse), 0);
        end
        rst = 1'b0;
        count_to_pulse(n, fh);
        check("R6 first period after reset (L-1)", n, 16);

        // R1/R2/R3: vector table, inputs applied at each pulse
        for (int i = 0; i < NV; i++) begin
            ratio_sel = VEC[i][9:8];
            mod_ctl   = VEC[i][7];
            count_to_pulse(n, fh);
            check($sformatf("R1/R2 vector %0d period", i), n, int'(VEC[i][6:0]));
            check("R3 pulse low after pulse", int'(fh), 0);
        end

        // R4/R5: mid-period changes do not alter the running period
        ratio_sel = 2'b00; mod_ctl = 1'b0;
        repeat (3) @(negedge clk);
        ratio_sel = 2'b11; mod_ctl = 1'b1;
        count_to_pulse(n, fh);
        check("R4 R5 running period kept after mid change", n + 3, 8);
        repeat (10) @(negedge clk);
        ratio_sel = 2'b00; mod_ctl = 1'b0;
        count_to_pulse(n, fh);
        check("R5 new ratio after boundary", n + 10, 65);
        count_to_pulse(n, fh);
        check("R4 late change applies one boundary later", n, 8);

        // R6: reset in mid-period reloads and restarts
        repeat (5) @(negedge clk);
        rst = 1'b1;
        ratio_sel = 2'b00; mod_ctl = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R6 pulse low in mid-period reset", int'(div_pulse), 0);
        end
        rst = 1'b0;
        count_to_pulse(n, fh);
        check("R6 first period after mid reset (L-1)", n, 7);
        count_to_pulse(n, fh);
        check("R1 period after reset restart", n, 8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule